// File: doc/BRIEF.md
# Interrupt Mask and Aggregation Controller

This block gathers level-sensitive interrupt requests from up to twenty peripheral lines and one software-generated request. It combines them into two processor-facing outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each output has its own enable mask. Firmware raises mask bits through a set register and lowers them through a separate clear register, so it never needs a read-modify-write sequence that an interrupt could split.

All registers are 32 bits wide and sit on a simple register bus. A write takes effect on the clock edge. A read returns data combinationally in the same cycle. The IRQ group of registers starts at offset 0x000. The FIQ group repeats the same layout at offset 0x100. Priority resolution and nesting are left to software.

Top module: `irq_mask_agg`

## Requirements
- R1: The signal register (offset 0x04, or 0x104 in the FIQ group) returns the live request level of every mapped source. A bus write to it changes nothing.
- R2: A write to the enable register (0x08, or 0x108 in the FIQ group) sets each enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bits unchanged.
- R3: A write to the clear register (0x0C, or 0x10C in the FIQ group) clears each enable bit whose write-data bit is 1 and leaves every other bit alone. The clear register always reads 0.
- R4: After reset, both enable masks are zero, the software request is low, and both irq_o and fiq_o are low.
- R5: irq_o equals the OR of (signal AND IRQ enable). It is registered, so it changes on the first clock edge after the change that causes it.
- R6: Line n of src_i appears at bit n, for n in 3..6 and 10..19. Bits 0, 2, 7, 8, 9 and 20..31 always read 0 in the signal and enable registers, whatever the inputs and writes.
- R7: A write to offset 0x10 with data bit 1 set raises the software request, which appears at signal bit 1. A write with data bit 0 set lowers it, and lowering wins when both bits are set. The register reads 0.
- R8: The FIQ group has its own mask, independent of the IRQ mask. fiq_o equals the OR of (signal AND FIQ enable), registered in the same way as irq_o.
- R9: The status register (offset 0x00 or 0x100) reads (signal AND enable) for its group. In the FIQ status register, bit 0 reads 1 whenever any FIQ source is pending. In the IRQ status register, bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level requests from the peripherals; line n maps to bit n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
Register reads are combinational, so the bench checks read data in the same low clock phase in which it drives the address. A mask write commits on the next rising edge and is visible at the following sample point. irq_o and fiq_o lag their cause by one more edge. After a source line changes, the bench first confirms that the output still holds its old value before the edge, then checks it after exactly one edge. After a mask write, it checks the output one edge after the write commits. All inputs are driven on the falling edge, and all outputs are sampled just after it.

// File: rtl/irq_mask_agg.sv
module irq_mask_agg #(
  parameter int          NSRC     = 20,
  parameter int          AW       = 12,
  parameter logic [31:0] SRC_MAP  = 32'h000F_FC78,
  parameter int          SWI_BIT  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [31:0] SWI_M   = 32'h1 << SWI_BIT;
  localparam logic [31:0] EN_MASK = SRC_MAP | SWI_M;
  localparam logic [7:0]  OFF_STAT = 8'h00;
  localparam logic [7:0]  OFF_SIG  = 8'h04;
  localparam logic [7:0]  OFF_EN   = 8'h08;
  localparam logic [7:0]  OFF_CLR  = 8'h0C;
  localparam logic [7:0]  OFF_SWI  = 8'h10;

  logic [31:0] src_w, sig, irq_en, fiq_en, irq_pend, fiq_pend;
  logic        swi;
  logic        in_map, fsel, wr;
  logic [7:0]  off;

  for (genvar i = 0; i < 32; i++) begin : g_src
    if (i < NSRC) begin : g_line
      assign src_w[i] = src_i[i];
    end else begin : g_none
      assign src_w[i] = 1'b0;
    end
  end

  assign sig      = (src_w & SRC_MAP) | (swi ? SWI_M : 32'h0);
  assign irq_pend = sig & irq_en;
  assign fiq_pend = sig & fiq_en;

  assign in_map = (bus_addr[AW-1:9] == '0);
  assign fsel   = bus_addr[8];
  assign off    = bus_addr[7:0];
  assign wr     = bus_sel & bus_we & in_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      fiq_en <= '0;
    end else if (wr) begin
      if (off == OFF_EN) begin
        if (fsel) fiq_en <= fiq_en | (bus_wdata & EN_MASK);
        else      irq_en <= irq_en | (bus_wdata & EN_MASK);
      end else if (off == OFF_CLR) begin
        if (fsel) fiq_en <= fiq_en & ~bus_wdata;
        else      irq_en <= irq_en & ~bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swi <= 1'b0;
    else if (wr && off == OFF_SWI) begin
      if (bus_wdata[0])      swi <= 1'b0;
      else if (bus_wdata[1]) swi <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_pend;
      fiq_o <= |fiq_pend;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && in_map) begin
      case (off)
        OFF_STAT: bus_rdata = fsel ? (fiq_pend | {31'b0, |fiq_pend}) : irq_pend;
        OFF_SIG:  bus_rdata = sig;
        OFF_EN:   bus_rdata = fsel ? fiq_en : irq_en;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: enable bits fall only through a clear write
  a_r2_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && off == OFF_CLR && !fsel) |=> (($past(irq_en) & ~irq_en) == '0));

  // R3: a clear write leaves none of its bits enabled
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_CLR && fsel) |=> ((fiq_en & $past(bus_wdata)) == '0));

  // R5: IRQ output follows the pending set one edge later
  a_r5_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(sig & irq_en))));

  // R6: reserved positions never read back set
  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && in_map && (off == OFF_SIG || off == OFF_EN))
      |-> ((bus_rdata & ~EN_MASK) == '0));

  // R9: FIQ status bit 0 reflects any other pending bit
  a_r9_fiq_any: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && in_map && fsel && off == OFF_STAT)
      |-> (bus_rdata[0] == |bus_rdata[31:1]));
endmodule

// File: tb/irq_mask_agg_tb.sv
module irq_mask_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  localparam logic [11:0] STAT = 12'h000, SIG = 12'h004, EN = 12'h008,
                          CLR = 12'h00C, SWI = 12'h010, FQ = 12'h100;

  always #2 clk = ~clk;

  irq_mask_agg u_dut (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    sel = 1; we = 0; addr = a; #1; d = rdata; sel = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R4 irq_o", {31'b0, irq}, 32'h0);
    check("R4 fiq_o", {31'b0, fiq}, 32'h0);
    rd(EN, d);      check("R4 irq enable", d, 32'h0);
    rd(FQ + EN, d); check("R4 fiq enable", d, 32'h0);
    rd(SIG, d);     check("R4 swi low", d, 32'h0);
  endtask

  task automatic t_signal;
    logic [31:0] d;
    @(negedge clk); src = 20'hFFFFF;
    rd(SIG, d); check("R1 R6 all lines", d, 32'h000F_FC78);
    wr(SIG, 32'h0);
    rd(SIG, d); check("R1 write ignored", d, 32'h000F_FC78);
    src = 20'h00400;
    rd(SIG, d); check("R1 R6 line 10 only", d, 32'h0000_0400);
    src = 20'h00387;
    rd(SIG, d); check("R6 reserved lines", d, 32'h0);
    src = '0;
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(EN, 32'h18);
    rd(EN, d); check("R2 set", d, 32'h18);
    wr(EN, 32'h8);
    rd(EN, d); check("R2 zero bits keep", d, 32'h18);
    wr(EN, 32'hFFFF_FFFF);
    rd(EN, d); check("R6 enable map", d, 32'h000F_FC7A);
    wr(CLR, 32'h10);
    rd(EN, d); check("R3 clear one", d, 32'h000F_FC6A);
    rd(CLR, d); check("R3 clear reads 0", d, 32'h0);
    rd(FQ + EN, d); check("R8 fiq mask independent", d, 32'h0);
    wr(CLR, 32'hFFFF_FFFF);
    rd(EN, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(EN, 32'h400);
    src = 20'h00400;
    #1; check("R5 before edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R5 after edge", {31'b0, irq}, 32'h1);
    rd(STAT, d); check("R9 irq status", d, 32'h400);
    src = 20'h00800;
    @(negedge clk);
    check("R5 masked line", {31'b0, irq}, 32'h0);
    rd(STAT, d); check("R9 irq status masked", d, 32'h0);
    src = '0;
    wr(CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_swi;
    logic [31:0] d;
    wr(SWI, 32'h2);
    rd(SIG, d); check("R7 swi set", d, 32'h2);
    rd(SWI, d); check("R7 swi reads 0", d, 32'h0);
    wr(EN, 32'h2);
    @(negedge clk);
    check("R7 R5 swi raises irq", {31'b0, irq}, 32'h1);
    wr(SWI, 32'h3);
    rd(SIG, d); check("R7 clear wins", d, 32'h0);
    @(negedge clk);
    check("R5 irq drops", {31'b0, irq}, 32'h0);
    wr(CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_fiq;
    logic [31:0] d;
    wr(FQ + EN, 32'h1000);
    rd(FQ + EN, d); check("R8 fiq set", d, 32'h1000);
    src = 20'h01000;
    @(negedge clk);
    check("R8 fiq_o", {31'b0, fiq}, 32'h1);
    check("R8 irq_o stays", {31'b0, irq}, 32'h0);
    rd(FQ + STAT, d); check("R9 fiq status any", d, 32'h1001);
    rd(FQ + SIG, d);  check("R1 fiq signal", d, 32'h1000);
    wr(EN, 32'h1000);
    rd(STAT, d); check("R9 irq bit0 zero", d, 32'h1000);
    wr(FQ + CLR, 32'h1000);
    rd(FQ + EN, d); check("R3 fiq clear", d, 32'h0);
    @(negedge clk);
    check("R8 fiq_o drops", {31'b0, fiq}, 32'h0);
    src = '0;
  endtask

  initial begin
    #1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signal();
    t_enable();
    t_irq();
    t_swi();
    t_fiq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule